// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps one reservation for a processor core so that a load-linked / store-conditional pair can perform an atomic read-modify-write. A load-linked sets a link flag and records which address granule was read. A later store-conditional may write memory only if the flag is still set and its address falls in the recorded granule. Any exception, any exception return and any snooped write from another agent to the recorded granule break the reservation. Every store-conditional consumes the reservation, whether it commits or not.

The core drives its load-linked, store-conditional, exception and snoop events into the monitor once per cycle. The monitor answers in the same cycle with a store permission, which gates the memory write enable, and with the one-bit result that is written to the destination register. The memory array and the coherence logic that produces the snoop events are outside the block.

Top module: `rsv_monitor`

## Requirements
- R1: After reset the link flag is clear, so a store-conditional issued before any load-linked gives scCommit=0 and scResult=0.
- R2: A store-conditional whose granule matches a live reservation gives scCommit=1 and scResult=1 combinationally, in the same cycle scValid is high.
- R3: A failing store-conditional gives scCommit=0 and scResult=0, so the memory write is suppressed and software sees 0.
- R4: Every store-conditional clears the link flag, so a second store-conditional without a new load-linked between them fails.
- R5: Addresses are compared on bits [ADDR_W-1:GRANULE_LG2] only; any offset inside the recorded granule matches, and an address in another granule fails.
- R6: excTaken or excReturn high in a cycle clears the link flag; a load-linked issued in that same cycle does not create a reservation.
- R7: snoopWrValid with snoopWrAddr in the recorded granule clears the link flag; a snooped write to another granule leaves it intact.
- R8: A new load-linked replaces any earlier reservation, taking the new granule.
- R9: A store-conditional in the same cycle as excTaken or as a snoop hit on the recorded granule fails.
- R10: A load-linked in the same cycle as a store-conditional or a snoop hit: the store-conditional is judged against the earlier reservation, and the new reservation stands afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| llValid | input | 1 | Load-linked issued this cycle |
| llAddr | input | ADDR_W | Load-linked address |
| scValid | input | 1 | Store-conditional issued this cycle |
| scAddr | input | ADDR_W | Store-conditional address |
| excTaken | input | 1 | An exception is taken this cycle |
| excReturn | input | 1 | An exception return executes this cycle |
| snoopWrValid | input | 1 | Another agent writes memory this cycle |
| snoopWrAddr | input | ADDR_W | Address of the snooped write |
| scCommit | output | 1 | Store-conditional may write memory |
| scResult | output | 1 | Value for the destination register (1 success, 0 failure) |

## Verification
The bench builds the block with ADDR_W=32 and GRANULE_LG2=4, so a granule is 16 bytes. Offsets 0x0 and 0xF inside one granule, and the address 0x10 just past it, can then be driven directly, which exercises both sides of the granule boundary for store-conditional and snoop compares. A 32-bit address leaves room for granules far apart, so a replaced reservation cannot alias the new one.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // Strobes from the control to the address datapath.
  typedef struct packed {
    logic loadTag;   // capture the load-linked granule
  } rsvStrobes_t;
endpackage

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsvStrobes_t       strobes,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic              snoopWrValid,
  input  logic [ADDR_W-1:0] snoopWrAddr,
  output logic              scMatch,
  output logic              snoopHit
);
  localparam int TAG_W = ADDR_W - GRANULE_LG2;

  logic [TAG_W-1:0] tagQ;
  logic [TAG_W-1:0] llTag;
  logic [TAG_W-1:0] scTag;
  logic [TAG_W-1:0] snoopTag;

  generate
    if (GRANULE_LG2 > 0) begin : g_granule
      assign llTag    = llAddr[ADDR_W-1:GRANULE_LG2];
      assign scTag    = scAddr[ADDR_W-1:GRANULE_LG2];
      assign snoopTag = snoopWrAddr[ADDR_W-1:GRANULE_LG2];
      logic unusedLowBits;
      assign unusedLowBits = ^{llAddr[GRANULE_LG2-1:0], scAddr[GRANULE_LG2-1:0],
                               snoopWrAddr[GRANULE_LG2-1:0]};
    end else begin : g_byte
      assign llTag    = llAddr;
      assign scTag    = scAddr;
      assign snoopTag = snoopWrAddr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ <= '0;
    end else if (strobes.loadTag) begin
      tagQ <= llTag;
    end
  end

  assign scMatch  = (scTag == tagQ);
  assign snoopHit = snoopWrValid && (snoopTag == tagQ);
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        llValid,
  input  logic        scValid,
  input  logic        excTaken,
  input  logic        excReturn,
  input  logic        scMatch,
  input  logic        snoopHit,
  output rsvStrobes_t strobes,
  output logic        scCommit
);
  logic linkQ;
  logic linkNext;
  logic flush;

  assign flush = excTaken || excReturn;

  // Priority: exception events, then a new load-linked, then consumers.
  always_comb begin
    linkNext = linkQ;
    if (flush) begin
      linkNext = 1'b0;
    end else if (llValid) begin
      linkNext = 1'b1;
    end else if (scValid || snoopHit) begin
      linkNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkQ <= 1'b0;
    end else begin
      linkQ <= linkNext;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.loadTag = llValid && !flush;
  end

  assign scCommit = scValid && linkQ && scMatch && !excTaken && !snoopHit;
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              llValid,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic              excTaken,
  input  logic              excReturn,
  input  logic              snoopWrValid,
  input  logic [ADDR_W-1:0] snoopWrAddr,
  output logic              scCommit,
  output logic              scResult
);
  rsvStrobes_t strobes;
  logic        scMatch;
  logic        snoopHit;

  rsv_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .llValid   (llValid),
    .scValid   (scValid),
    .excTaken  (excTaken),
    .excReturn (excReturn),
    .scMatch   (scMatch),
    .snoopHit  (snoopHit),
    .strobes   (strobes),
    .scCommit  (scCommit)
  );

  rsv_datapath #(
    .ADDR_W      (ADDR_W),
    .GRANULE_LG2 (GRANULE_LG2)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .llAddr       (llAddr),
    .scAddr       (scAddr),
    .snoopWrValid (snoopWrValid),
    .snoopWrAddr  (snoopWrAddr),
    .scMatch      (scMatch),
    .snoopHit     (snoopHit)
  );

  assign scResult = scCommit;
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int ADDR_W      = 32,
  parameter int GRANULE_LG2 = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              llValid,
  input logic              scValid,
  input logic [ADDR_W-1:0] scAddr,
  input logic              excTaken,
  input logic              excReturn,
  input logic              snoopWrValid,
  input logic [ADDR_W-1:0] snoopWrAddr,
  input logic              scCommit,
  input logic              scResult
);
  p_commit_needs_sc_r2: assert property (@(posedge clk) disable iff (!rstN)
    scCommit |-> (scValid && scResult));

  p_fail_returns_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !scCommit) |-> !scResult);

  p_sc_consumes_link_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !llValid) |=> !scCommit);

  p_flush_breaks_link_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken || excReturn) |=> !scCommit);

  p_exc_same_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> !scCommit);

  p_snoop_same_granule_r7: assert property (@(posedge clk) disable iff (!rstN)
    scCommit |-> !(snoopWrValid && ((snoopWrAddr >> GRANULE_LG2) == (scAddr >> GRANULE_LG2))));
endmodule

bind rsv_monitor rsv_monitor_chk #(
  .ADDR_W      (ADDR_W),
  .GRANULE_LG2 (GRANULE_LG2)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .llValid      (llValid),
  .scValid      (scValid),
  .scAddr       (scAddr),
  .excTaken     (excTaken),
  .excReturn    (excReturn),
  .snoopWrValid (snoopWrValid),
  .snoopWrAddr  (snoopWrAddr),
  .scCommit     (scCommit),
  .scResult     (scResult)
);

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;
  localparam int ADDR_W = 32;
  localparam int GRANULE_LG2 = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              llValid = 1'b0;
  logic [ADDR_W-1:0] llAddr = '0;
  logic              scValid = 1'b0;
  logic [ADDR_W-1:0] scAddr = '0;
  logic              excTaken = 1'b0;
  logic              excReturn = 1'b0;
  logic              snoopWrValid = 1'b0;
  logic [ADDR_W-1:0] snoopWrAddr = '0;
  logic              scCommit;
  logic              scResult;

  int checks = 0;
  int failures = 0;
  logic sCommit;
  logic sResult;

  rsv_monitor #(.ADDR_W(ADDR_W), .GRANULE_LG2(GRANULE_LG2)) i_rsv_monitor (
    .clk(clk), .rstN(rstN), .llValid(llValid), .llAddr(llAddr),
    .scValid(scValid), .scAddr(scAddr), .excTaken(excTaken),
    .excReturn(excReturn), .snoopWrValid(snoopWrValid),
    .snoopWrAddr(snoopWrAddr), .scCommit(scCommit), .scResult(scResult)
  );

  always #5 clk = ~clk;

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired (expected run to end)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // One cycle: drive at negedge, sample combinational outputs, pass the posedge.
  task automatic cyc(input logic ll, input logic [ADDR_W-1:0] la,
                     input logic sc, input logic [ADDR_W-1:0] sa,
                     input logic ex, input logic er,
                     input logic sn, input logic [ADDR_W-1:0] na);
    llValid = ll; llAddr = la; scValid = sc; scAddr = sa;
    excTaken = ex; excReturn = er; snoopWrValid = sn; snoopWrAddr = na;
    #2;
    sCommit = scCommit;
    sResult = scResult;
    @(negedge clk);
    llValid = 0; scValid = 0; excTaken = 0; excReturn = 0; snoopWrValid = 0;
  endtask

  task automatic expect_sc(input string req, input logic exp);
    checks++;
    if (sCommit !== exp || sResult !== exp) begin
      failures++;
      $display("FAIL %s: commit=%b result=%b expected %b", req, sCommit, sResult, exp);
    end
  endtask

  task automatic do_ll(input logic [ADDR_W-1:0] a);
    cyc(1, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_sc(input logic [ADDR_W-1:0] a);
    cyc(0, 0, 1, a, 0, 0, 0, 0);
  endtask

  task automatic t_reset;  // R1
    cyc(0, 0, 1, 32'h0, 0, 0, 0, 0);
    expect_sc("R1 sc during reset", 0);
    rstN = 1'b1;
    @(negedge clk);
    do_sc(32'h0);
    expect_sc("R1 sc after reset with no ll", 0);
  endtask

  task automatic t_basic;  // R2, R3
    do_ll(32'h1000);
    do_sc(32'h1000);
    expect_sc("R2 ll then sc same address", 1);
    do_sc(32'h1000);
    expect_sc("R3 sc with clear link", 0);
  endtask

  task automatic t_sc_clears;  // R4, R3
    do_ll(32'h2000);
    do_sc(32'h3000);
    expect_sc("R3 sc other address fails", 0);
    do_sc(32'h2000);
    expect_sc("R4 failed sc consumed link", 0);
    do_ll(32'h2000);
    do_sc(32'h2000);
    expect_sc("R2 relinked sc", 1);
    do_sc(32'h2000);
    expect_sc("R4 second sc fails", 0);
  endtask

  task automatic t_granule;  // R5
    do_ll(32'h4000);
    do_sc(32'h400F);
    expect_sc("R5 offset 0xF in granule", 1);
    do_ll(32'h400C);
    do_sc(32'h4000);
    expect_sc("R5 offset 0x0 in granule", 1);
    do_ll(32'h400F);
    do_sc(32'h4010);
    expect_sc("R5 next granule fails", 0);
  endtask

  task automatic t_exception;  // R6
    do_ll(32'h5000);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    do_sc(32'h5000);
    expect_sc("R6 exception cleared link", 0);
    do_ll(32'h5000);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    do_sc(32'h5000);
    expect_sc("R6 exception return cleared link", 0);
    cyc(1, 32'h5000, 0, 0, 1, 0, 0, 0);
    do_sc(32'h5000);
    expect_sc("R6 ll with exception no link", 0);
  endtask

  task automatic t_snoop;  // R7
    do_ll(32'h6000);
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h6010);
    do_sc(32'h6000);
    expect_sc("R7 snoop other granule keeps link", 1);
    do_ll(32'h6000);
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h6008);
    do_sc(32'h6000);
    expect_sc("R7 snoop same granule breaks link", 0);
  endtask

  task automatic t_replace;  // R8
    do_ll(32'h7000);
    do_ll(32'h8000);
    do_sc(32'h7000);
    expect_sc("R8 old reservation replaced", 0);
    do_ll(32'h7000);
    do_ll(32'h8000);
    do_sc(32'h8004);
    expect_sc("R8 new reservation commits", 1);
  endtask

  task automatic t_same_cycle;  // R9
    do_ll(32'h9000);
    cyc(0, 0, 1, 32'h9000, 1, 0, 0, 0);
    expect_sc("R9 sc with exception fails", 0);
    do_ll(32'h9000);
    cyc(0, 0, 1, 32'h9000, 0, 0, 1, 32'h9004);
    expect_sc("R9 sc with snoop hit fails", 0);
    do_ll(32'h9000);
    cyc(0, 0, 1, 32'h9000, 0, 0, 1, 32'hA000);
    expect_sc("R9 sc with snoop miss commits", 1);
  endtask

  task automatic t_ll_overlap;  // R10
    do_ll(32'hB000);
    cyc(1, 32'hC000, 1, 32'hB000, 0, 0, 0, 0);
    expect_sc("R10 sc judged on earlier reservation", 1);
    do_sc(32'hC000);
    expect_sc("R10 new reservation survives sc", 1);
    cyc(1, 32'hD000, 1, 32'hD000, 0, 0, 0, 0);
    expect_sc("R10 sc with ll and no prior link", 0);
    cyc(1, 32'hE000, 0, 0, 0, 0, 1, 32'hD000);
    do_sc(32'hE000);
    expect_sc("R10 ll beats snoop on old granule", 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_sc_clears();
    t_granule();
    t_exception();
    t_snoop();
    t_replace();
    t_same_cycle();
    t_ll_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule